// File: doc/BRIEF.md
# Dual-Clock FIFO with Narrow-Port Packing

This block carries 36-bit long words from a writer in one clock domain to a reader in an unrelated clock domain. The write port can be set to take a whole long word per transfer, an 18-bit half per transfer, or a 9-bit lane per transfer. In the narrow settings the block assembles the long word from consecutive accepted transfers. It stores the long word only when the last piece arrives, so a partly assembled word never shows up in any flag.

The read port runs in one of two modes. In standard mode an availability flag says the store holds data, and a qualified read moves the next long word into the output register. In fall-through mode the block moves the next long word into the output register without being asked, and the availability flag then means the output register holds a word that has not yet been consumed. The two pointers cross domains as gray code through two-stage synchronisers. The occupancy flags on each side come from the local pointer and the synchronised copy of the remote one.

The bus size and the read mode are captured while the shared active-low reset is held. That reset also clears both pointers.

Top module: `bmf_top`

## Requirements
- R1: While reset is held and after it is released, `rd_avail` is low, `wr_room` is high and `rd_data` is zero.
- R2: A port transfer happens only on a rising edge of that port's clock where its select, enable and direction inputs are all high. A write attempt missing any one of the three stores nothing.
- R3: With size code 0 (full 36-bit transfers), long words leave the read port unchanged and in the order they were written.
- R4: With size code 1 (half transfers), the first accepted transfer supplies bits 17:0 and the second supplies bits 35:18. Each half is taken from `wr_data[17:0]`. Only the second transfer makes the word visible to the reader.
- R5: With size code 2 (lane transfers), four accepted transfers fill bits 8:0, 17:9, 26:18 and 35:27 in that order. Each lane is taken from `wr_data[8:0]`. After three lanes the reader still sees no data.
- R6: In fall-through mode (`rd_fwft` high at reset), a long word written into an empty FIFO is present on `rd_data` with `rd_avail` high after the third reader clock rising edge that follows the write edge, or after the fourth. The word then stays there until it is read.
- R7: In standard mode, a write into an empty FIFO raises `rd_avail` after the second reader edge that follows the write edge, or after the third. `rd_data` changes only on an accepted read, and it keeps its old value while the FIFO is empty.
- R8: After DEPTH long words are stored with no reads, `wr_room` is low and further writes are ignored. The ignored words never reach the reader.
- R9: A read from a full FIFO raises `wr_room` after the second writer clock edge that follows the read edge, or after the third.
- R10: A read attempt while `rd_avail` is low does not move the read pointer. The next word written is the next word read.
- R11: Size and mode are taken from the pins only while reset is held. Changing the pins after reset has no effect.
- R12: Through repeated fill and drain cycles that wrap both pointers, every stored long word is delivered exactly once and in order. Each pointer's gray code changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer clock |
| rd_clk | input | 1 | Reader clock |
| rst_n | input | 1 | Active-low reset for both sides; size and mode are sampled while low |
| wr_size | input | 2 | Write bus size: 0 long word, 1 half word, 2 lane; 3 acts as 0 |
| rd_fwft | input | 1 | 1 selects fall-through read mode, 0 selects standard mode |
| wr_sel | input | 1 | Write port select, active high |
| wr_en | input | 1 | Write enable, active high |
| wr_dir | input | 1 | Direction, 1 means write |
| wr_data | input | 36 | Write data; the narrow sizes use the low bits |
| wr_room | output | 1 | High when the store can accept a long word |
| rd_sel | input | 1 | Read port select, active high |
| rd_en | input | 1 | Read enable, active high |
| rd_dir | input | 1 | Direction, 1 means read |
| rd_data | output | 36 | Output register |
| rd_avail | output | 1 | Standard mode: store not empty. Fall-through mode: output register valid |

## Verification
A wrong pointer or a bad gray step shows up at the reader as a word that is missing, repeated or out of order, within a few reader cycles of the failing write. It also shows up as an availability or room flag that stays stuck after a fill or a drain. Wrong packing state shows up as swapped or merged lanes in the first long word read after the narrow transfers. It can also show up as `rd_avail` rising before the last lane. A wrong mode or size latch changes the edge count at which `rd_avail` rises and the way data is presented, starting with the first word after reset.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
    localparam int LONG_W = 36;
    localparam int HALF_W = 18;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        SZ_LONG = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LANE = 2'd2
    } bus_size_e;
endpackage

// File: rtl/bmf_sync.sv
module bmf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            q    <= '0;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/bmf_wside.sv
// Writer domain: narrow-port packing, write pointer and room flag.
// DEPTH must be a power of two, at least 4.
module bmf_wside
    import bmf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  bus_size_e               size_pin,
    input  logic                    sel,
    input  logic                    en,
    input  logic                    dir,
    input  logic [LONG_W-1:0]       din,
    input  logic [$clog2(DEPTH):0]  rgray_s,
    output logic [$clog2(DEPTH):0]  wgray,
    output logic [$clog2(DEPTH):0]  wbin,
    output logic                    we,
    output logic [$clog2(DEPTH)-1:0] waddr,
    output logic [LONG_W-1:0]       wdata,
    output logic                    room
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [1:0]        lane;
        logic [LONG_W-1:0] acc;
        logic [AW:0]       bin;
        logic [AW:0]       gray;
    } wstate_t;

    wstate_t   st_d, st_q;
    bus_size_e size_q;
    logic      full, accept;
    logic [1:0] last;
    logic [LONG_W-1:0] merged;
    logic [AW:0] nbin;

    // size is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) size_q <= size_pin;
    end

    always_comb begin
        st_d   = st_q;
        we     = 1'b0;
        merged = st_q.acc;
        nbin   = st_q.bin + 1'b1;
        full   = (st_q.gray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        case (size_q)
            SZ_HALF: last = 2'd1;
            SZ_LANE: last = 2'd3;
            default: last = 2'd0;
        endcase
        case (size_q)
            SZ_HALF: merged[st_q.lane[0]*HALF_W +: HALF_W] = din[HALF_W-1:0];
            SZ_LANE: merged[st_q.lane*LANE_W +: LANE_W]    = din[LANE_W-1:0];
            default: merged = din;
        endcase
        accept = sel && en && dir && !full;
        if (accept) begin
            st_d.acc = merged;
            if (st_q.lane == last) begin
                we        = 1'b1;
                st_d.lane = 2'd0;
                st_d.bin  = nbin;
                st_d.gray = nbin ^ (nbin >> 1);
            end else begin
                st_d.lane = st_q.lane + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdata = merged;
    assign waddr = st_q.bin[AW-1:0];
    assign room  = !full;
    assign wgray = st_q.gray;
    assign wbin  = st_q.bin;
endmodule

// File: rtl/bmf_rside.sv
// Reader domain: read pointer, output register, standard and fall-through modes.
module bmf_rside
    import bmf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fwft_pin,
    input  logic                     sel,
    input  logic                     en,
    input  logic                     dir,
    input  logic [$clog2(DEPTH):0]   wgray_s,
    input  logic [LONG_W-1:0]        mem_q,
    output logic [$clog2(DEPTH)-1:0] raddr,
    output logic [$clog2(DEPTH):0]   rgray,
    output logic [$clog2(DEPTH):0]   rbin,
    output logic [LONG_W-1:0]        dout,
    output logic                     avail,
    output logic                     fwft_mode
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0]       bin;
        logic [AW:0]       gray;
        logic [LONG_W-1:0] data;
        logic              ov;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    fwft_q, empty, req, pop, load;
    logic [AW:0] nbin;

    always_ff @(posedge clk) begin
        if (!rst_n) fwft_q <= fwft_pin;
    end

    always_comb begin
        st_d  = st_q;
        nbin  = st_q.bin + 1'b1;
        empty = (st_q.gray == wgray_s);
        req   = sel && en && dir;
        if (fwft_q) begin
            pop  = req && st_q.ov;
            load = (!st_q.ov || pop) && !empty;
            if (load) st_d.ov = 1'b1;
            else if (pop) st_d.ov = 1'b0;
        end else begin
            pop  = req && !empty;
            load = pop;
        end
        if (load) begin
            st_d.data = mem_q;
            st_d.bin  = nbin;
            st_d.gray = nbin ^ (nbin >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr     = st_q.bin[AW-1:0];
    assign rgray     = st_q.gray;
    assign rbin      = st_q.bin;
    assign dout      = st_q.data;
    assign avail     = fwft_q ? st_q.ov : !empty;
    assign fwft_mode = fwft_q;
endmodule

// File: rtl/bmf_top.sv
module bmf_top
    import bmf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        wr_clk,
    input  logic        rd_clk,
    input  logic        rst_n,
    input  logic [1:0]  wr_size,
    input  logic        rd_fwft,
    input  logic        wr_sel,
    input  logic        wr_en,
    input  logic        wr_dir,
    input  logic [35:0] wr_data,
    output logic        wr_room,
    input  logic        rd_sel,
    input  logic        rd_en,
    input  logic        rd_dir,
    output logic [35:0] rd_data,
    output logic        rd_avail
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]       w_gray, w_bin, w_gray_s;
    logic [AW:0]       r_gray, r_bin, r_gray_s;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [LONG_W-1:0] mem_wdata, mem_q;
    logic              r_fwft;
    logic [LONG_W-1:0] store [DEPTH];

    bmf_wside #(.DEPTH(DEPTH)) i_wside (
        .clk(wr_clk), .rst_n(rst_n), .size_pin(bus_size_e'(wr_size)),
        .sel(wr_sel), .en(wr_en), .dir(wr_dir), .din(wr_data),
        .rgray_s(r_gray_s), .wgray(w_gray), .wbin(w_bin), .we(mem_we),
        .waddr(mem_waddr), .wdata(mem_wdata), .room(wr_room)
    );

    bmf_rside #(.DEPTH(DEPTH)) i_rside (
        .clk(rd_clk), .rst_n(rst_n), .fwft_pin(rd_fwft),
        .sel(rd_sel), .en(rd_en), .dir(rd_dir), .wgray_s(w_gray_s),
        .mem_q(mem_q), .raddr(mem_raddr), .rgray(r_gray), .rbin(r_bin),
        .dout(rd_data), .avail(rd_avail), .fwft_mode(r_fwft)
    );

    bmf_sync #(.W(AW+1)) i_w2r (.clk(rd_clk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s));
    bmf_sync #(.W(AW+1)) i_r2w (.clk(wr_clk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s));

    always_ff @(posedge wr_clk) begin
        if (mem_we) store[mem_waddr] <= mem_wdata;
    end

    assign mem_q = store[mem_raddr];
endmodule

// File: rtl/bmf_chk.sv
module bmf_chk #(
    parameter int AW = 4
) (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        rst_n,
    input logic        wr_sel,
    input logic        wr_en,
    input logic        wr_dir,
    input logic        wr_room,
    input logic [AW:0] w_bin,
    input logic [AW:0] w_gray,
    input logic        rd_sel,
    input logic        rd_en,
    input logic        rd_dir,
    input logic        rd_avail,
    input logic [35:0] rd_data,
    input logic [AW:0] r_bin,
    input logic [AW:0] r_gray,
    input logic        r_fwft
);
    p_no_overflow_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!wr_room && wr_sel && wr_en && wr_dir) |=> $stable(w_bin));

    p_no_underflow_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!r_fwft && !rd_avail && rd_sel && rd_en && rd_dir) |=> $stable(r_bin));

    p_std_hold_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!r_fwft && !(rd_avail && rd_sel && rd_en && rd_dir)) |=> $stable(rd_data));

    p_fwft_hold_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (r_fwft && rd_avail && !(rd_sel && rd_en && rd_dir)) |=> (rd_avail && $stable(rd_data)));

    p_wgray_step_r12: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    p_rgray_step_r12: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

bind bmf_top bmf_chk #(.AW(AW)) i_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_sel(wr_sel), .wr_en(wr_en), .wr_dir(wr_dir), .wr_room(wr_room),
    .w_bin(w_bin), .w_gray(w_gray),
    .rd_sel(rd_sel), .rd_en(rd_en), .rd_dir(rd_dir), .rd_avail(rd_avail),
    .rd_data(rd_data), .r_bin(r_bin), .r_gray(r_gray), .r_fwft(r_fwft)
);

// File: tb/test_bmf_top.sv
module test_bmf_top;
    localparam int DEPTH = 16;

    logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic        rd_fwft = 1'b0;
    logic        wr_sel = 1'b0, wr_en = 1'b0, wr_dir = 1'b0;
    logic [35:0] wr_data = '0;
    logic        wr_room;
    logic        rd_sel = 1'b0, rd_en = 1'b0, rd_dir = 1'b0;
    logic [35:0] rd_data;
    logic        rd_avail;
    int          total = 0, bad = 0;

    always #10 wr_clk = ~wr_clk;   // 50 MHz writer clock
    always #13 rd_clk = ~rd_clk;

    bmf_top #(.DEPTH(DEPTH)) i_bmf_top (.*);

    localparam logic [35:0] VEC [8] = '{
        36'h0_0000_0001, 36'hF_FFFF_FFFF, 36'hA_5A5A_5A5A, 36'h5_A5A5_A5A5,
        36'h8_0000_0000, 36'h1_2345_6789, 36'hE_DCBA_9876, 36'h0_F0F0_F0F0
    };

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sz, input logic fw);
        @(negedge wr_clk);
        rst_n = 1'b0; wr_size = sz; rd_fwft = fw;
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (4) @(posedge rd_clk);
        repeat (2) @(negedge wr_clk);
        #3 rst_n = 1'b1;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic wr_try(input logic s, input logic e, input logic d, input logic [35:0] v);
        @(negedge wr_clk);
        wr_sel = s; wr_en = e; wr_dir = d; wr_data = v;
        @(negedge wr_clk);
        wr_sel = 1'b0; wr_en = 1'b0; wr_dir = 1'b0;
    endtask

    task automatic wr_count(input logic [35:0] v, output int n);
        @(negedge wr_clk);
        wr_sel = 1'b1; wr_en = 1'b1; wr_dir = 1'b1; wr_data = v;
        @(posedge wr_clk);
        #1 wr_en = 1'b0;
        n = 0;
        while (!rd_avail && n < 12) begin
            @(posedge rd_clk); #1; n++;
        end
    endtask

    task automatic rd_one(output logic [35:0] q);
        @(negedge rd_clk);
        q = rd_data;
        rd_sel = 1'b1; rd_en = 1'b1; rd_dir = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        if (!rd_fwft) q = rd_data;
    endtask

    task automatic rd_count(output logic [35:0] q, output int n);
        @(negedge rd_clk);
        rd_sel = 1'b1; rd_en = 1'b1; rd_dir = 1'b1;
        @(posedge rd_clk);
        #1 rd_en = 1'b0;
        q = rd_data;
        n = 0;
        while (!wr_room && n < 12) begin
            @(posedge wr_clk); #1; n++;
        end
    endtask

    task automatic idle_rd(input int k);
        repeat (k) @(negedge rd_clk);
    endtask

    initial begin
        #3_000_000;
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [35:0] q;
        int n;

        // ---- standard mode, long words ----
        do_reset(2'd0, 1'b0);
        chk(rd_avail == 1'b0, "R1 avail after reset", {35'd0, rd_avail}, 36'd0);
        chk(wr_room == 1'b1, "R1 room after reset", {35'd0, wr_room}, 36'd1);
        chk(rd_data == '0, "R1 data after reset", rd_data, 36'd0);

        wr_try(1'b0, 1'b1, 1'b1, 36'h1_1111_1111);
        wr_try(1'b1, 1'b0, 1'b1, 36'h2_2222_2222);
        wr_try(1'b1, 1'b1, 1'b0, 36'h3_3333_3333);
        idle_rd(8);
        chk(rd_avail == 1'b0, "R2 unqualified writes ignored", {35'd0, rd_avail}, 36'd0);

        wr_count(36'hC_0FFE_E123, n);
        chk(n >= 2 && n <= 3, "R7 std avail edge count", 36'(n), 36'd2);
        chk(rd_data == '0, "R7 no data before read", rd_data, 36'd0);
        rd_one(q);
        chk(q == 36'hC_0FFE_E123, "R7 data after read", q, 36'hC_0FFE_E123);
        idle_rd(5);
        chk(rd_avail == 1'b0 && rd_data == 36'hC_0FFE_E123, "R7 hold while empty", rd_data, 36'hC_0FFE_E123);

        rd_one(q);   // read while empty
        chk(rd_data == 36'hC_0FFE_E123, "R10 empty read ignored", rd_data, 36'hC_0FFE_E123);
        wr_try(1'b1, 1'b1, 1'b1, 36'h7_7777_0000);
        idle_rd(5);
        rd_one(q);
        chk(q == 36'h7_7777_0000, "R10 next word intact", q, 36'h7_7777_0000);

        // table walk R3 (std read-back)
        for (int i = 0; i < 8; i++) wr_try(1'b1, 1'b1, 1'b1, VEC[i]);
        idle_rd(5);
        for (int i = 0; i < 8; i++) begin
            rd_one(q);
            chk(q == VEC[i], "R3 std table word", q, VEC[i]);
        end

        // fill, overflow attempt, drain; two rounds plus a short one to wrap pointers
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < DEPTH; i++) wr_try(1'b1, 1'b1, 1'b1, 36'hA00 + 36'(r*256 + i));
            chk(wr_room == 1'b0, "R8 full after DEPTH writes", {35'd0, wr_room}, 36'd0);
            wr_try(1'b1, 1'b1, 1'b1, 36'hB_ADBA_DBAD);
            idle_rd(5);
            rd_count(q, n);
            chk(q == 36'hA00 + 36'(r*256), "R12 first of fill", q, 36'hA00 + 36'(r*256));
            chk(n >= 2 && n <= 3, "R9 room edge count", 36'(n), 36'd2);
            for (int i = 1; i < DEPTH; i++) begin
                rd_one(q);
                chk(q == 36'hA00 + 36'(r*256 + i), "R12 fill order", q, 36'hA00 + 36'(r*256 + i));
            end
            idle_rd(5);
            chk(rd_avail == 1'b0, "R8 dropped word absent", {35'd0, rd_avail}, 36'd0);
        end
        for (int i = 0; i < 3; i++) wr_try(1'b1, 1'b1, 1'b1, 36'h5500 + 36'(i));
        idle_rd(5);
        for (int i = 0; i < 3; i++) begin
            rd_one(q);
            chk(q == 36'h5500 + 36'(i), "R12 across wrap", q, 36'h5500 + 36'(i));
        end

        // ---- fall-through mode, long words ----
        do_reset(2'd0, 1'b1);
        chk(rd_avail == 1'b0 && wr_room == 1'b1, "R1 fwft reset flags", {34'd0, wr_room, rd_avail}, 36'd2);
        rd_one(q);   // read while not ready
        idle_rd(3);
        chk(rd_avail == 1'b0, "R10 fwft read while not ready", {35'd0, rd_avail}, 36'd0);
        wr_count(36'h9_8765_4321, n);
        chk(n >= 3 && n <= 4, "R6 fwft edge count", 36'(n), 36'd3);
        chk(rd_data == 36'h9_8765_4321, "R6 fwft word presented", rd_data, 36'h9_8765_4321);
        rd_one(q);
        idle_rd(2);
        chk(rd_avail == 1'b0, "R6 fwft avail drops after read", {35'd0, rd_avail}, 36'd0);
        for (int i = 0; i < 8; i++) wr_try(1'b1, 1'b1, 1'b1, VEC[i]);
        idle_rd(5);
        for (int i = 0; i < 8; i++) begin
            rd_one(q);
            chk(q == VEC[i], "R3 fwft table word", q, VEC[i]);
        end

        // ---- half-word packing, standard mode ----
        do_reset(2'd1, 1'b0);
        wr_try(1'b1, 1'b1, 1'b1, {18'h2AAAA, 18'h1_2345});
        idle_rd(8);
        chk(rd_avail == 1'b0, "R4 half not counted", {35'd0, rd_avail}, 36'd0);
        wr_try(1'b1, 1'b1, 1'b1, {18'h15555, 18'h3_0F0F});
        idle_rd(5);
        rd_one(q);
        chk(q == {18'h3_0F0F, 18'h1_2345}, "R4 half order", q, {18'h3_0F0F, 18'h1_2345});

        // ---- lane packing, fall-through; pins changed after reset ----
        do_reset(2'd2, 1'b1);
        wr_size = 2'd0; rd_fwft = 1'b0;
        wr_try(1'b1, 1'b1, 1'b1, {27'h5A5A5A5, 9'h101});
        wr_try(1'b1, 1'b1, 1'b1, {27'h5A5A5A5, 9'h0A2});
        wr_try(1'b1, 1'b1, 1'b1, {27'h5A5A5A5, 9'h1C3});
        idle_rd(8);
        chk(rd_avail == 1'b0, "R5 three lanes not counted", {35'd0, rd_avail}, 36'd0);
        wr_count({27'h5A5A5A5, 9'h044}, n);
        chk(n >= 3 && n <= 4, "R11 latched fwft timing", 36'(n), 36'd3);
        chk(rd_data == {9'h044, 9'h1C3, 9'h0A2, 9'h101}, "R5 lane order",
            rd_data, {9'h044, 9'h1C3, 9'h0A2, 9'h101});
        rd_one(q);
        chk(q == {9'h044, 9'h1C3, 9'h0A2, 9'h101}, "R11 latched size and mode",
            q, {9'h044, 9'h1C3, 9'h0A2, 9'h101});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule